// File: doc/BRIEF.md
# Nested Translation Buffer (Guest Virtual to Host Physical)

This block caches finished two-stage address translations. Each entry links a guest virtual page straight to a host physical page. No intermediate guest physical address is kept. A nested page walker installs an entry after it completes a walk. It reports the page size the guest used and the page size the host used. The buffer keeps the smaller of the two, so a large entry is only made when both stages mapped the whole region at that size or larger.

There are three separate fully associative pools: one for 4 KB pages, one for 2 MB pages and one for 1 GB pages. Every lookup probes all three pools in parallel. The registered response appears on the cycle after the request and carries a hit flag and the host physical address. The offset bits below the matched page size pass through unchanged from the guest address. A single-address invalidate removes every entry in any pool that covers a given guest address. A flush clears the whole buffer in one cycle.

Top module: `g2h_xlate_buf`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rsp_valid` and `rsp_hit` are 0. After reset every lookup misses.
- R2: A lookup that hits returns the stored host page with the guest address bits below the page size copied unchanged. The copied bits are [11:0] for 4 KB, [20:0] for 2 MB and [29:0] for 1 GB.
- R3: The installed page size is the smaller of `fill_gsize` and `fill_hsize`. The encoding is 0 = 4 KB, 1 = 2 MB, 2 = 1 GB, and 3 is treated as 1 GB. An address in the same larger region but outside the installed page misses.
- R4: Each pool replaces entries in round-robin order, starting at slot 0 after reset. A pool with N slots evicts its oldest entry on the (N+1)th fill of distinct pages.
- R5: A fill whose page already has a valid entry in the target pool overwrites that entry and does not advance the pool's replacement pointer.
- R6: When more than one pool hits, the smallest page size wins.
- R7: `inv_valid` clears every entry, in every pool, whose page covers `inv_gva`. Other entries are unaffected.
- R8: `flush` clears all entries in one cycle. A fill in the same cycle is dropped.
- R9: A lookup in the same cycle as a fill whose installed page covers the lookup address reports a miss. The fill still completes.
- R10: `rsp_valid` is high exactly on the cycle after a cycle with `lk_valid` high. On a miss `rsp_hpa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_gva | input | VA_W | Guest virtual address to translate |
| rsp_valid | output | 1 | Registered lookup response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_hpa | output | PA_W | Host physical address (0 on miss) |
| fill_valid | input | 1 | Install an entry from the walker |
| fill_gva | input | VA_W | Guest virtual address of the walk |
| fill_hpa | input | PA_W | Host physical address of the walk |
| fill_gsize | input | 2 | Guest page size code |
| fill_hsize | input | 2 | Host page size code |
| inv_valid | input | 1 | Single-address invalidate |
| inv_gva | input | VA_W | Address to invalidate |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench installs walks where the guest and host sizes differ. It then probes the neighbouring 4 KB page, because a design that took the larger size would hit there. It refills a resident 1 GB page and then adds one more page. If the refill wrongly advanced the pointer, the wrong victim would be evicted and the refilled page would survive. Overlapping 2 MB and 4 KB entries check the size priority, and an invalidate inside both checks that both are removed. A same-cycle lookup and fill must report a miss and then a hit, which catches a design that forwards the entry early or loses the fill.

// File: rtl/g2h_pkg.sv
package g2h_pkg;
  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  localparam int unsigned NUM_POOLS = 3;

  // code 3 behaves as the largest size
  function automatic pg_size_e pg_clamp(input logic [1:0] code);
    return (code == 2'd3) ? PG_1G : pg_size_e'(code);
  endfunction

  function automatic pg_size_e pg_min(input logic [1:0] a, input logic [1:0] b);
    pg_size_e ca, cb;
    ca = pg_clamp(a);
    cb = pg_clamp(b);
    return (ca < cb) ? ca : cb;
  endfunction

  function automatic int unsigned pg_ofs(input int unsigned idx);
    return (idx == 0) ? 12 : (idx == 1) ? 21 : 30;
  endfunction
endpackage

// File: rtl/g2h_pool.sv
module g2h_pool #(
  parameter int unsigned N    = 64,
  parameter int unsigned OFS  = 12,
  parameter int unsigned VA_W = 48,
  parameter int unsigned PA_W = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VA_W-1:0] lk_va,
  input  logic            fl_en,
  input  logic [VA_W-1:0] fl_va,
  input  logic [PA_W-1:0] fl_pa,
  input  logic            inv_en,
  input  logic [VA_W-1:0] inv_va,
  input  logic            flush,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_pa
);
  localparam int unsigned TW = VA_W - OFS;
  localparam int unsigned DW = PA_W - OFS;
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  vld;
  logic [TW-1:0] tag [N];
  logic [DW-1:0] dat [N];
  logic [PW-1:0] ptr;

  logic [N-1:0]  lk_vec, fl_vec, inv_vec;
  logic [PW-1:0] slot;
  logic [DW-1:0] sel_dat;

  always_comb begin
    sel_dat = '0;
    slot    = ptr;
    for (int i = 0; i < N; i++) begin
      lk_vec[i]  = vld[i] && (tag[i] == lk_va[VA_W-1:OFS]);
      fl_vec[i]  = vld[i] && (tag[i] == fl_va[VA_W-1:OFS]);
      inv_vec[i] = vld[i] && (tag[i] == inv_va[VA_W-1:OFS]);
      if (lk_vec[i]) sel_dat = dat[i];
      if (fl_vec[i]) slot = PW'(i);
    end
  end

  assign lk_hit = |lk_vec;
  assign lk_pa  = {sel_dat, lk_va[OFS-1:0]};

  // valid bits and pointer: reset and clear in one cycle
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      if (inv_en) vld <= vld & ~inv_vec;
      if (fl_en) begin
        vld[slot] <= 1'b1;
        if (fl_vec == '0) ptr <= (ptr == PW'(N-1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  // payload arrays without reset
  always_ff @(posedge clk) begin
    if (fl_en && !flush) begin
      tag[slot] <= fl_va[VA_W-1:OFS];
      dat[slot] <= fl_pa[PA_W-1:OFS];
    end
  end
endmodule

// File: rtl/g2h_xlate_buf.sv
module g2h_xlate_buf
  import g2h_pkg::*;
#(
  parameter int unsigned VA_W = 48,
  parameter int unsigned PA_W = 48,
  parameter int unsigned N_4K = 64,
  parameter int unsigned N_2M = 32,
  parameter int unsigned N_1G = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_gva,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [PA_W-1:0] rsp_hpa,
  input  logic            fill_valid,
  input  logic [VA_W-1:0] fill_gva,
  input  logic [PA_W-1:0] fill_hpa,
  input  logic [1:0]      fill_gsize,
  input  logic [1:0]      fill_hsize,
  input  logic            inv_valid,
  input  logic [VA_W-1:0] inv_gva,
  input  logic            flush
);
  pg_size_e eff;
  logic [NUM_POOLS-1:0] hit, coll;
  logic [PA_W-1:0]      pa [NUM_POOLS];
  logic [PA_W-1:0]      pick;

  assign eff = pg_min(fill_gsize, fill_hsize);

  for (genvar k = 0; k < NUM_POOLS; k++) begin : g_pool
    localparam int unsigned OFS = pg_ofs(k);
    localparam int unsigned NE  = (k == 0) ? N_4K : (k == 1) ? N_2M : N_1G;
    logic en;
    assign en      = fill_valid && (eff == pg_size_e'(k));
    assign coll[k] = en && (lk_gva[VA_W-1:OFS] == fill_gva[VA_W-1:OFS]);

    g2h_pool #(.N(NE), .OFS(OFS), .VA_W(VA_W), .PA_W(PA_W)) u_pool (
      .clk(clk), .rst(rst), .lk_va(lk_gva),
      .fl_en(en), .fl_va(fill_gva), .fl_pa(fill_hpa),
      .inv_en(inv_valid), .inv_va(inv_gva), .flush(flush),
      .lk_hit(hit[k]), .lk_pa(pa[k])
    );
  end

  always_comb begin
    if (hit[0])      pick = pa[0];
    else if (hit[1]) pick = pa[1];
    else             pick = pa[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_hpa   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|hit) && !(|coll);
      rsp_hpa   <= (lk_valid && (|hit) && !(|coll)) ? pick : '0;
    end
  end
endmodule

// File: rtl/g2h_xlate_buf_chk.sv
module g2h_xlate_buf_chk #(
  parameter int unsigned VA_W = 48,
  parameter int unsigned PA_W = 48
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_gva,
  input logic            fill_valid,
  input logic [VA_W-1:0] fill_gva,
  input logic            flush,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_hpa
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!rsp_valid && !rsp_hit));
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst) lk_valid |=> rsp_valid);
  // R10
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> !rsp_valid);
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_hpa[11:0] == $past(lk_gva[11:0])));
  // R9
  same_cycle_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && fill_valid && (lk_gva == fill_gva)) |=> !rsp_hit);
  // R8
  after_flush_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && lk_valid) |=> !rsp_hit);
  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_hpa == '0));
endmodule

bind g2h_xlate_buf g2h_xlate_buf_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_gva(lk_gva),
  .fill_valid(fill_valid), .fill_gva(fill_gva), .flush(flush),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hpa(rsp_hpa)
);

// File: tb/g2h_xlate_buf_tb.sv
module g2h_xlate_buf_tb;
  localparam int unsigned VA_W = 48;
  localparam int unsigned PA_W = 48;

  logic clk = 0;
  logic rst = 1;
  logic lk_valid = 0, fill_valid = 0, inv_valid = 0, flush = 0;
  logic [VA_W-1:0] lk_gva = '0, fill_gva = '0, inv_gva = '0;
  logic [PA_W-1:0] fill_hpa = '0;
  logic [1:0] fill_gsize = '0, fill_hsize = '0;
  logic rsp_valid, rsp_hit;
  logic [PA_W-1:0] rsp_hpa;

  int checks = 0, fails = 0;
  logic [PA_W:0] exp_q [$];   // {hit, hpa}
  string tag_q [$];
  bit done = 0;

  always #2.5 clk = ~clk;

  g2h_xlate_buf #(.VA_W(VA_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_gva(lk_gva),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hpa(rsp_hpa),
    .fill_valid(fill_valid), .fill_gva(fill_gva), .fill_hpa(fill_hpa),
    .fill_gsize(fill_gsize), .fill_hsize(fill_hsize),
    .inv_valid(inv_valid), .inv_gva(inv_gva), .flush(flush)
  );

  task automatic check(input string req, input logic [PA_W:0] act, input logic [PA_W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    lk_valid = 0; fill_valid = 0; inv_valid = 0; flush = 0;
  endtask

  task automatic lookup(input string req, input logic [VA_W-1:0] va,
                        input logic hit, input logic [PA_W-1:0] pa);
    @(negedge clk);
    clear_in();
    lk_valid = 1; lk_gva = va;
    exp_q.push_back({hit, hit ? pa : '0});
    tag_q.push_back(req);
    @(negedge clk);
    clear_in();
  endtask

  task automatic fill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                      input logic [1:0] gs, input logic [1:0] hs);
    @(negedge clk);
    clear_in();
    fill_valid = 1; fill_gva = va; fill_hpa = pa; fill_gsize = gs; fill_hsize = hs;
    @(negedge clk);
    clear_in();
  endtask

  // monitor: pops expected items as responses arrive
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (exp_q.size() == 0) check("R10 unexpected response", 1, 0);
        else begin
          logic [PA_W:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {rsp_hit, rsp_hpa}, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: no response while in reset
    check("R1 reset rsp_valid", {rsp_valid, {PA_W{1'b0}}}, '0);
    @(negedge clk); rst = 0;
    check("R1 first cycle idle", {rsp_valid, rsp_hpa}, '0);
    lookup("R1 empty after reset", 48'h0000_1234_5678, 0, 0);

    // R3: guest 4K, host 2M -> 4K entry
    fill(48'h0000_1234_5000, 48'h0000_ABCD_E000, 2'd0, 2'd1);
    lookup("R2 4K offset pass", 48'h0000_1234_5ABC, 1, 48'h0000_ABCD_EABC);
    lookup("R3 neighbour 4K misses", 48'h0000_1234_6000, 0, 0);
    // R3: guest 1G, host 2M -> 2M entry
    fill(48'h0040_0020_0000, 48'h0000_8040_0000, 2'd2, 2'd1);
    lookup("R2 2M offset pass", 48'h0040_003F_FFFF, 1, 48'h0000_805F_FFFF);
    lookup("R3 next 2M misses", 48'h0040_0040_0000, 0, 0);

    // R4: four 1G pages (code 3 on host counts as 1G), fifth evicts first
    for (int k = 1; k <= 4; k++)
      fill(48'(k) << 30, 48'(k + 8) << 30, 2'd2, 2'd3);
    lookup("R2 1G offset pass", (48'd1 << 30) + 48'h123_4567, 1, (48'd9 << 30) + 48'h123_4567);
    fill(48'd5 << 30, 48'd13 << 30, 2'd2, 2'd2);
    lookup("R4 oldest evicted", 48'd1 << 30, 0, 0);
    lookup("R4 second kept", 48'd2 << 30, 1, 48'd10 << 30);
    lookup("R4 newest present", 48'd5 << 30, 1, 48'd13 << 30);

    // R5: refill page 2 in place, pointer stays on slot 1 (page 2)
    fill(48'd2 << 30, 48'd20 << 30, 2'd2, 2'd2);
    lookup("R5 refill updates", 48'd2 << 30, 1, 48'd20 << 30);
    fill(48'd6 << 30, 48'd14 << 30, 2'd2, 2'd2);
    lookup("R5 refilled slot is victim", 48'd2 << 30, 0, 0);
    lookup("R5 page 3 survives", 48'd3 << 30, 1, 48'd11 << 30);

    // R6: overlapping 2M and 4K, smaller wins
    fill(48'h0000_0060_0000, 48'h0000_0100_0000, 2'd1, 2'd1);
    fill(48'h0000_0060_3000, 48'h0000_0777_7000, 2'd0, 2'd0);
    lookup("R6 4K wins", 48'h0000_0060_3010, 1, 48'h0000_0777_7010);
    lookup("R6 2M elsewhere", 48'h0000_0060_4010, 1, 48'h0000_0100_4010);

    // R7: single invalidate clears both covering entries
    @(negedge clk); clear_in(); inv_valid = 1; inv_gva = 48'h0000_0060_3500;
    @(negedge clk); clear_in();
    lookup("R7 2M cleared", 48'h0000_0060_4010, 0, 0);
    lookup("R7 4K cleared", 48'h0000_0060_3010, 0, 0);
    lookup("R7 other 4K kept", 48'h0000_1234_5ABC, 1, 48'h0000_ABCD_EABC);

    // R9: same-cycle lookup and fill
    @(negedge clk); clear_in();
    lk_valid = 1; lk_gva = 48'h0000_0900_0123;
    fill_valid = 1; fill_gva = 48'h0000_0900_0000; fill_hpa = 48'h0000_0333_3000;
    fill_gsize = 2'd0; fill_hsize = 2'd0;
    exp_q.push_back('0); tag_q.push_back("R9 same-cycle miss");
    @(negedge clk); clear_in();
    lookup("R9 fill completed", 48'h0000_0900_0123, 1, 48'h0000_0333_3123);

    // R10: no response on an idle cycle
    @(negedge clk); clear_in();
    @(negedge clk);
    check("R10 idle no rsp", {rsp_valid, {PA_W{1'b0}}}, '0);

    // R8: flush clears everything, a simultaneous fill is dropped
    @(negedge clk); clear_in(); flush = 1;
    fill_valid = 1; fill_gva = 48'h0000_0A00_0000; fill_hpa = 48'h0000_0444_4000;
    fill_gsize = 2'd0; fill_hsize = 2'd0;
    @(negedge clk); clear_in();
    lookup("R8 4K gone", 48'h0000_1234_5ABC, 0, 0);
    lookup("R8 1G gone", 48'd5 << 30, 0, 0);
    lookup("R8 fill dropped", 48'h0000_0A00_0000, 0, 0);

    repeat (3) @(negedge clk);
    check("R10 all responses seen", (PA_W+1)'(exp_q.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule